// File: doc/BRIEF.md
# Indexed System Counter

This block is a free-running 64-bit system counter shared by the cores of a multi-core cluster. It counts ticks of a reference clock enable. A one-hot select makes it count every tick, every second tick or every fourth tick. Other agents in the system rely on the counter, so once it is started software only gates the interrupt outputs and leaves the count running.

Software reaches every internal register through a window of two bus words. The word at byte offset 0x4 (`bus_word` = 1) holds an index. The word at byte offset 0x0 (`bus_word` = 0) is a data port that reads or writes the internal register named by the most recently written index. The internal registers are: control, the two halves of the count, a 32-bit compare value, a sticky pending mask, and a per-CPU interrupt enable mask. When the low half of the count equals the compare value while the counter is enabled, every CPU's pending bit is set. Each CPU's interrupt output is its pending bit gated by its enable bit.

Top module: `idx_sys_timer`

## Requirements
- R1: After reset the index, control word, interrupt enable mask, pending mask and count all read zero, and the compare value reads 0xFFFFFFFF.
- R2: A write with `bus_word`=1 loads the index, and reading that word returns it (low 8 bits, upper bits zero). A data access with `bus_word`=0 targets the internal register named by the index.
- R3: Control sits at index 0x00. Bit 0 enables counting and bits 10:8 hold the divider select. All other bits read zero. While bit 0 is clear the count holds.
- R4: Divider codes are one-hot. 3'b001 counts every reference tick, 3'b010 every second tick and 3'b100 every fourth tick. Any other code counts every tick. The tick phase restarts when counting is enabled.
- R5: The count is 64 bits wide. The low word reads at index 0x04 and the high word at index 0x08. Reading the low word captures the high word, and the index 0x08 read returns that capture.
- R6: The interrupt enable mask sits at index 0x30. Bits 3:0 map to CPUs 0 to 3, and bits 31:4 read zero. Writing it never stops or alters the count.
- R7: Compare sits at index 0x0C. While counting is enabled and the low count word equals compare, all four pending bits are set. The pending mask reads at index 0x10. Writing a 1 to bit i there clears CPU i's pending bit. In a cycle where a match and a clear coincide, the match wins. With counting disabled, no match is taken.
- R8: `irq_o[i]` is high exactly when pending bit i and enable bit i are both set. Masking an interrupt does not clear its pending bit.
- R9: Indices other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x30 read zero, and writes to them change nothing.
- R10: The count advances only in cycles where `ref_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference clock enable, one pulse per reference tick |
| bus_word | input | 1 | Word select: 0 is the data port, 1 is the index word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; captures the high count word when it reads the low word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| irq_o | output | 4 | Per-CPU interrupt, pending gated by enable |

## Verification
A compare match and a software clear of the pending mask can land in the same cycle. To provoke this, the bench sets compare to the current count while stopped. It then enables counting at divide-by-4, so the count sits on the compare value for four enabled cycles, and the clear write arrives during that window. The collision is judged by reading the pending mask afterwards, which must still be all ones. A later clear, taken once the count has moved on, must take effect, and only on the bits written.

// File: rtl/ist_pkg.sv
// Package ist_pkg
// Holds the shared constants of the indexed system counter: index values,
// field positions inside the control word and the one-hot divider codes.
package ist_pkg;
    localparam int IDX_W   = 8;
    localparam int DIV_W   = 3;
    localparam int EN_BIT  = 0;
    localparam int DIV_LSB = 8;

    localparam logic [IDX_W-1:0] IX_CTRL   = 8'h00;
    localparam logic [IDX_W-1:0] IX_CNT_LO = 8'h04;
    localparam logic [IDX_W-1:0] IX_CNT_HI = 8'h08;
    localparam logic [IDX_W-1:0] IX_CMP    = 8'h0C;
    localparam logic [IDX_W-1:0] IX_PEND   = 8'h10;
    localparam logic [IDX_W-1:0] IX_IRQEN  = 8'h30;

    localparam logic [DIV_W-1:0] DIV_BY2 = 3'b010;
    localparam logic [DIV_W-1:0] DIV_BY4 = 3'b100;
endpackage

// File: rtl/ist_prescale.sv
// Module ist_prescale
// Turns reference ticks into count ticks at 1/1, 1/2 or 1/4 of their rate.
// Assumes div is one-hot; any other code falls back to divide-by-1.
// The phase counter is cleared while counting is disabled.
module ist_prescale
    import ist_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [PH_W-1:0] ph_q;
    logic            by2;
    logic            by4;

    // Decode the divider select and form the count tick.
    always_comb begin
        by2  = (div == DIV_BY2);
        by4  = (div == DIV_BY4);
        tick = en && ref_tick &&
               ((!by2 && !by4) || (by2 && ph_q[0]) || (by4 && (&ph_q[1:0])));
    end

    // Advance the reference-tick phase while enabled; restart it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph_q <= '0;
        end else if (ref_tick) begin
            ph_q <= ph_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/ist_counter.sv
// Module ist_counter
// Holds the count, the captured high word and the per-CPU pending bits.
// Assumes DW < CNT_W <= 2*DW. A compare match sets every pending bit and
// wins over a clear in the same cycle.
module ist_counter #(
    parameter int NCPU  = 4,
    parameter int CNT_W = 64,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             lo_rd,
    input  logic [DW-1:0]    cmp,
    input  logic [NCPU-1:0]  pend_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-DW-1:0] hi_cap,
    output logic [NCPU-1:0]  pend
);
    localparam int HI_W = CNT_W - DW;

    logic match;

    // Compare the low count word against the compare value while running.
    always_comb begin
        match = en && (cnt[DW-1:0] == cmp);
    end

    // Advance the count on each prescaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Capture the high word whenever the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cap <= '0;
        end else if (lo_rd) begin
            hi_cap <= cnt[CNT_W-1 -: HI_W];
        end
    end

    for (genvar g = 0; g < NCPU; g++) begin : g_pend
        // Sticky pending bit of one CPU: set by match, cleared by software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else if (match) begin
                pend[g] <= 1'b1;
            end else if (pend_clr[g]) begin
                pend[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ist_regwin.sv
// Module ist_regwin
// Two-word register window: an index word and a data port that reaches the
// internal register named by the index. Unknown indices read zero and
// ignore writes. Read data is combinational.
module ist_regwin
    import ist_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int HI_W  = 32,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_word,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    cnt_lo,
    input  logic [HI_W-1:0]  hi_cap,
    input  logic [NCPU-1:0]  pend,
    output logic             ctrl_en,
    output logic [DIV_W-1:0] ctrl_div,
    output logic [NCPU-1:0]  ie,
    output logic [DW-1:0]    cmp,
    output logic [NCPU-1:0]  pend_clr,
    output logic             lo_rd
);
    logic [IDX_W-1:0] idx_q;
    logic             dat_wr;
    logic [DW-1:0]    ctrl_word;

    // Decode data-port strobes for the indexed register.
    always_comb begin
        dat_wr   = bus_wr && !bus_word;
        lo_rd    = bus_rd && !bus_word && (idx_q == IX_CNT_LO);
        pend_clr = (dat_wr && (idx_q == IX_PEND)) ? bus_wdata[NCPU-1:0] : '0;
    end

    // Assemble the control word and select the read data.
    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[EN_BIT]           = ctrl_en;
        ctrl_word[DIV_LSB +: DIV_W] = ctrl_div;
        if (bus_word) begin
            bus_rdata = DW'(idx_q);
        end else begin
            case (idx_q)
                IX_CTRL:   bus_rdata = ctrl_word;
                IX_CNT_LO: bus_rdata = cnt_lo;
                IX_CNT_HI: bus_rdata = DW'(hi_cap);
                IX_CMP:    bus_rdata = cmp;
                IX_PEND:   bus_rdata = DW'(pend);
                IX_IRQEN:  bus_rdata = DW'(ie);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Load the index word and the writable internal registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            ctrl_en  <= 1'b0;
            ctrl_div <= '0;
            ie       <= '0;
            cmp      <= '1;
        end else if (bus_wr) begin
            if (bus_word) begin
                idx_q <= bus_wdata[IDX_W-1:0];
            end else begin
                case (idx_q)
                    IX_CTRL: begin
                        ctrl_en  <= bus_wdata[EN_BIT];
                        ctrl_div <= bus_wdata[DIV_LSB +: DIV_W];
                    end
                    IX_CMP:   cmp <= bus_wdata;
                    IX_IRQEN: ie  <= bus_wdata[NCPU-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/idx_sys_timer.sv
// Module idx_sys_timer
// Top of the indexed system counter: register window, prescaler and counter.
// Assumes a single bus master that writes the index before each data access.
module idx_sys_timer
    import ist_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 64,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_tick,
    input  logic            bus_word,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NCPU-1:0] irq_o
);
    localparam int HI_W = CNT_W - DW;

    logic             ctrl_en;
    logic [DIV_W-1:0] ctrl_div;
    logic [NCPU-1:0]  ie_q;
    logic [DW-1:0]    cmp_q;
    logic [NCPU-1:0]  pend_clr;
    logic             lo_rd;
    logic             cnt_tick;
    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  hi_cap;
    logic [NCPU-1:0]  pend_q;

    ist_regwin #(.NCPU(NCPU), .HI_W(HI_W), .DW(DW)) u_win (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_lo(cnt_q[DW-1:0]), .hi_cap(hi_cap), .pend(pend_q),
        .ctrl_en(ctrl_en), .ctrl_div(ctrl_div), .ie(ie_q), .cmp(cmp_q),
        .pend_clr(pend_clr), .lo_rd(lo_rd)
    );

    ist_prescale #(.PH_W(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .ref_tick(ref_tick),
        .div(ctrl_div), .tick(cnt_tick)
    );

    ist_counter #(.NCPU(NCPU), .CNT_W(CNT_W), .DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(cnt_tick),
        .lo_rd(lo_rd), .cmp(cmp_q), .pend_clr(pend_clr),
        .cnt(cnt_q), .hi_cap(hi_cap), .pend(pend_q)
    );

    // Gate each CPU's pending bit by its enable bit.
    always_comb begin
        irq_o = pend_q & ie_q;
    end
endmodule

// File: rtl/ist_checker.sv
// Module ist_checker
// Temporal checks on the indexed system counter, bound to its top.
// Assumes it sees the top's internal counter, pending and control nets.
module ist_checker #(
    parameter int NCPU  = 4,
    parameter int CNT_W = 64,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             ctrl_en,
    input logic [2:0]       ctrl_div,
    input logic             cnt_tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [DW-1:0]    cmp_q,
    input logic [NCPU-1:0]  pend_q,
    input logic [NCPU-1:0]  pend_clr
);
    // R3: a stopped counter holds its value.
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> $stable(cnt_q));

    // R4: the count moves by at most one per cycle.
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R4: divide-by-2 never ticks in two adjacent cycles.
    a_r4_div2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && ctrl_div == 3'b010) |=> (!cnt_tick || ctrl_div != 3'b010));

    // R10: no reference tick, no count change.
    a_r10_no_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(cnt_q));

    // R7: a match while enabled sets every pending bit.
    a_r7_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && cnt_q[DW-1:0] == cmp_q) |=> (&pend_q));

    // R7: pending bits stay set unless a clear is written.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind idx_sys_timer ist_checker #(.NCPU(NCPU), .CNT_W(CNT_W), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ctrl_en(ctrl_en),
    .ctrl_div(ctrl_div), .cnt_tick(cnt_tick), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .pend_q(pend_q), .pend_clr(pend_clr)
);

// File: tb/idx_sys_timer_bench.sv
// Bench for idx_sys_timer: sweeps every divider code under two reference
// patterns and exercises the register window, compare and masking.
module idx_sys_timer_bench;
    localparam int PERIOD = 10;
    localparam int WDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        bus_word = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_run = 0;
    int n_fail = 0;
    int ref_mode = 0;
    int phase = 0;
    bit done = 1'b0;

    // Requirement model: tracks index and enable, counts enabled ref ticks.
    logic [7:0] m_idx = '0;
    bit         m_en = 1'b0;
    longint     m_refs = 0;

    idx_sys_timer u_idx_sys_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_word(bus_word),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // Reference tick pattern: always high, or high one cycle in three.
    always @(negedge clk) begin
        phase = (phase == 2) ? 0 : phase + 1;
        ref_tick = (ref_mode == 0) ? 1'b1 : (phase == 0);
    end

    // Model of the bus-visible enable and the ticks seen while enabled.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = '0;
            m_en  = 1'b0;
        end else begin
            if (m_en && ref_tick) m_refs = m_refs + 1;
            if (bus_wr) begin
                if (bus_word) m_idx = bus_wdata[7:0];
                else if (m_idx == 8'h00) m_en = bus_wdata[0];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Bus write; entered and left at a falling edge.
    task automatic wr(input logic w, input logic [31:0] d);
        bus_word = w; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Bus read; data sampled shortly after the falling edge.
    task automatic rd(input logic w, output logic [31:0] v);
        bus_word = w; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] ix, output logic [31:0] v);
        wr(1'b1, {24'h0, ix});
        rd(1'b0, v);
    endtask

    function automatic int div_of(input int code);
        return (code == 2) ? 2 : (code == 4) ? 4 : 1;
    endfunction

    // One enabled window with a divider code; optionally rewrite the IE mask.
    task automatic window(input int code, input int extra, input bit ie_poke, input string req);
        logic [31:0] lo0, lo1;
        longint base;
        wr(1'b1, 32'h0);
        wr(1'b0, code << 8);
        rd_idx(8'h04, lo0);
        base = m_refs;
        wr(1'b1, 32'h0);
        wr(1'b0, (code << 8) | 1);
        if (ie_poke) begin
            wr(1'b1, 32'h30);
            wr(1'b0, 32'h0);
            wr(1'b1, 32'h0);
        end
        repeat (extra) @(negedge clk);
        wr(1'b0, code << 8);
        rd_idx(8'h04, lo1);
        chk(req, lo1 - lo0, 32'((m_refs - base) / div_of(code)));
    endtask

    initial begin
        #(PERIOD * WDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(1'b1, v);          chk("R1 index", v, 32'h0);
        rd_idx(8'h00, v);     chk("R1 ctrl", v, 32'h0);
        rd_idx(8'h04, v);     chk("R1 cnt lo", v, 32'h0);
        rd_idx(8'h08, v);     chk("R1 cnt hi", v, 32'h0);
        rd_idx(8'h0C, v);     chk("R1 cmp", v, 32'hFFFF_FFFF);
        rd_idx(8'h10, v);     chk("R1 pend", v, 32'h0);
        rd_idx(8'h30, v);     chk("R1 irqen", v, 32'h0);
        chk("R1 irq_o", {28'h0, irq_o}, 32'h0);

        // R2: index readback keeps 8 bits
        wr(1'b1, 32'hABCD_1234);
        rd(1'b1, v);          chk("R2 index readback", v, 32'h34);

        // R3: control fields, other bits zero
        wr(1'b1, 32'h0);
        wr(1'b0, 32'hFFFF_FFFE);
        rd(1'b0, v);          chk("R3 ctrl fields", v, 32'h700);
        wr(1'b0, 32'h0);

        // R6: enable mask width
        wr(1'b1, 32'h30);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v);          chk("R6 irqen width", v, 32'hF);
        wr(1'b0, 32'h0);

        // R9: unknown indices
        wr(1'b1, 32'h14); wr(1'b0, 32'hFFFF_FFFF); rd(1'b0, v); chk("R9 idx14", v, 32'h0);
        wr(1'b1, 32'h2C); wr(1'b0, 32'hFFFF_FFFF); rd(1'b0, v); chk("R9 idx2c", v, 32'h0);
        rd_idx(8'h00, v);     chk("R9 ctrl intact", v, 32'h0);
        rd_idx(8'h0C, v);     chk("R9 cmp intact", v, 32'hFFFF_FFFF);

        // R4 / R10: all eight divider codes under two reference patterns
        for (int m = 0; m < 2; m++) begin
            ref_mode = m;
            for (int c = 0; c < 8; c++) begin
                window(c, 9 + c, 1'b0, (m == 0) ? "R4 divider sweep" : "R10 sparse ref");
            end
        end
        ref_mode = 0;

        // R6: rewriting the enable mask while running leaves counting intact
        window(2, 11, 1'b1, "R6 ie write keeps counting");

        // R5: high word captured on low read
        rd_idx(8'h04, v);
        rd_idx(8'h08, v);     chk("R5 hi capture", v, 32'h0);

        // R7 / R8: compare, masking and the match-versus-clear collision
        wr(1'b1, 32'h30); wr(1'b0, 32'h5);
        rd_idx(8'h04, lo);
        wr(1'b1, 32'h0C); wr(1'b0, lo);
        wr(1'b1, 32'h10); wr(1'b0, 32'hF);
        repeat (3) @(negedge clk);
        rd(1'b0, v);          chk("R7 no match while off", v, 32'h0);
        wr(1'b1, 32'h0);  wr(1'b0, 32'h401);
        wr(1'b1, 32'h10); wr(1'b0, 32'hF);
        wr(1'b1, 32'h0);  wr(1'b0, 32'h400);
        rd_idx(8'h10, v);     chk("R7 match beats clear", v, 32'hF);
        chk("R8 irq gated", {28'h0, irq_o}, 32'h5);
        wr(1'b0, 32'h3);
        rd(1'b0, v);          chk("R7 partial clear", v, 32'hC);
        chk("R8 irq after clear", {28'h0, irq_o}, 32'h4);
        wr(1'b1, 32'h30); wr(1'b0, 32'h0);
        chk("R8 masked", {28'h0, irq_o}, 32'h0);
        rd_idx(8'h10, v);     chk("R8 mask keeps pending", v, 32'hC);
        rd_idx(8'h04, v);     chk("R4 div4 count in collision run", v, lo + 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule